// File: doc/BRIEF.md
# Interrupt Event Latch Controller

This block gathers eight status-change events from a clock-reference monitoring subsystem and holds each one in a sticky bit until software collects it. It watches a set of status levels: the lock indication, the index of the reference in use, the loop operating mode, and one activity bit and one usability bit per reference. It finds the transitions it cares about by comparing each input with its registered value from the cycle before. A recorded event drives the active-low interrupt output only when its enable bit is set. Events are recorded whether or not they are enabled.

Software reaches the block through a simple parallel register bus. Address 0x12 returns the event register, and reading it clears every latched event. Address 0x13 holds the read/write enable mask. If a new event arrives in the same cycle as a clearing read, it survives into the next read. After reset the first clock cycle only captures the inputs, so status that is already present at reset does not raise events.

Top module: `irq_event_ctrl`

## Requirements
- R1: While reset is held and after it is released, the event register and the enable register both read as 0, and the interrupt output is 1.
- R2: A write to address 0x13 stores all eight data bits in the enable register, and a read of 0x13 returns them.
- R3: The event register at 0x12 is sticky. Bit 7 means lock lost, bit 6 means the selected reference changed, bit 5 means the operating mode changed, bit 4 means some reference gained activity, bit 3 means some reference lost activity, bit 2 means some reference became usable, bit 1 means some reference became unusable, and bit 0 means any activity or usability bit changed. An event sets its bit whatever the enable value is.
- R4: The interrupt output is 0 exactly when some event bit and the matching enable bit are both 1.
- R5: A read of 0x12 returns the current events, and at the next clock edge it clears all eight bits.
- R6: An event detected in the same cycle as a clearing read stays set after that read.
- R7: Writes to 0x12 have no effect, and reads of any address other than 0x12 or 0x13 return 0.
- R8: A falling edge of the lock input sets bit 7. A rising edge does not.
- R9: A 0-to-1 change on any reference activity bit sets bit 4, and a 1-to-0 change sets bit 3.
- R10: A 0-to-1 change on any reference usability bit sets bit 2, and a 1-to-0 change sets bit 1.
- R11: A change of the selected-reference index sets bit 6, and a change of the mode value sets bit 5.
- R12: In the first clock cycle after reset the inputs are captured and no event is raised, even if they are nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lock_ok | input | 1 | Loop lock status level |
| act_ref_sel | input | SEL_W | Index of the reference in use |
| pll_mode | input | MODE_W | Loop operating mode |
| ref_active | input | NUM_REFS | Per-reference signal activity |
| ref_usable | input | NUM_REFS | Per-reference usability |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Two situations are hard to reach from the ports. One is a new transition that lands in exactly the cycle of a clearing read. The bench produces it in directed steps by changing a status input in the same negedge slot that raises the read strobe on 0x12. The other is status that is already active when reset is released. The bench sets every input to a nonzero pattern while reset is held, then reads the event register once the synchronizer has let go. A long pseudo-random phase then mixes transitions, enable writes, clearing reads and unmapped accesses. A cycle-level model in the bench predicts the read data and the interrupt level.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;
  localparam int unsigned NUM_EVT = 8;

  localparam int unsigned EV_ANY_CHG  = 0;
  localparam int unsigned EV_USE_LOST = 1;
  localparam int unsigned EV_USE_GAIN = 2;
  localparam int unsigned EV_ACT_LOST = 3;
  localparam int unsigned EV_ACT_GAIN = 4;
  localparam int unsigned EV_MODE_CHG = 5;
  localparam int unsigned EV_SEL_CHG  = 6;
  localparam int unsigned EV_LOCK_LOS = 7;

  typedef logic [NUM_EVT-1:0] evt_vec_t;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect
  import irq_evt_pkg::*;
#(
  parameter int unsigned NUM_REFS = 8,
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned MODE_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lock_ok,
  input  logic [SEL_W-1:0]    act_ref_sel,
  input  logic [MODE_W-1:0]   pll_mode,
  input  logic [NUM_REFS-1:0] ref_active,
  input  logic [NUM_REFS-1:0] ref_usable,
  output evt_vec_t            evt_pulse
);
  logic                prev_lock_q;
  logic [SEL_W-1:0]    prev_sel_q;
  logic [MODE_W-1:0]   prev_mode_q;
  logic [NUM_REFS-1:0] prev_act_q;
  logic [NUM_REFS-1:0] prev_use_q;
  logic                primed_q;

  evt_vec_t raw_evt;

  always_comb begin
    raw_evt = '0;
    raw_evt[EV_LOCK_LOS] = prev_lock_q & ~lock_ok;
    raw_evt[EV_SEL_CHG]  = (act_ref_sel != prev_sel_q);
    raw_evt[EV_MODE_CHG] = (pll_mode != prev_mode_q);
    raw_evt[EV_ACT_GAIN] = |(ref_active & ~prev_act_q);
    raw_evt[EV_ACT_LOST] = |(~ref_active & prev_act_q);
    raw_evt[EV_USE_GAIN] = |(ref_usable & ~prev_use_q);
    raw_evt[EV_USE_LOST] = |(~ref_usable & prev_use_q);
    raw_evt[EV_ANY_CHG]  = |((ref_active ^ prev_act_q) | (ref_usable ^ prev_use_q));
    evt_pulse = primed_q ? raw_evt : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_lock_q <= 1'b0;
      prev_sel_q  <= '0;
      prev_mode_q <= '0;
      prev_act_q  <= '0;
      prev_use_q  <= '0;
      primed_q    <= 1'b0;
    end else begin
      prev_lock_q <= lock_ok;
      prev_sel_q  <= act_ref_sel;
      prev_mode_q <= pll_mode;
      prev_act_q  <= ref_active;
      prev_use_q  <= ref_usable;
      primed_q    <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_event_latch.sv
module irq_event_latch
  import irq_evt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  evt_vec_t evt_pulse,
  input  logic     evt_clr,
  input  logic     ena_we,
  input  evt_vec_t ena_wdata,
  output evt_vec_t evt_q,
  output evt_vec_t ena_q,
  output logic     irq_n
);
  evt_vec_t evt_d;
  evt_vec_t ena_d;

  always_comb begin
    evt_d = (evt_clr ? '0 : evt_q) | evt_pulse;
    ena_d = ena_we ? ena_wdata : ena_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      ena_q <= '0;
    end else begin
      evt_q <= evt_d;
      ena_q <= ena_d;
    end
  end

  assign irq_n = ~|(evt_q & ena_q);
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_evt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] EVT_ADDR = 8'h12,
  parameter logic [ADDR_W-1:0] ENA_ADDR = 8'h13
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  evt_vec_t          evt_q,
  input  evt_vec_t          ena_q,
  output logic              evt_clr,
  output logic              ena_we,
  output evt_vec_t          ena_wdata,
  output logic [7:0]        bus_rdata
);
  logic hit_evt;
  logic hit_ena;

  always_comb begin
    hit_evt   = (bus_addr == EVT_ADDR);
    hit_ena   = (bus_addr == ENA_ADDR);
    evt_clr   = bus_rd & hit_evt;
    ena_we    = bus_wr & hit_ena;
    ena_wdata = bus_wdata;
    if (hit_evt)      bus_rdata = evt_q;
    else if (hit_ena) bus_rdata = ena_q;
    else              bus_rdata = '0;
  end
endmodule

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl
  import irq_evt_pkg::*;
#(
  parameter int unsigned NUM_REFS = 8,
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned MODE_W   = 2,
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] EVT_ADDR = 8'h12,
  parameter logic [ADDR_W-1:0] ENA_ADDR = 8'h13,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lock_ok,
  input  logic [SEL_W-1:0]    act_ref_sel,
  input  logic [MODE_W-1:0]   pll_mode,
  input  logic [NUM_REFS-1:0] ref_active,
  input  logic [NUM_REFS-1:0] ref_usable,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  output logic                irq_n
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  evt_vec_t evt_pulse;
  evt_vec_t evt_q;
  evt_vec_t ena_q;
  evt_vec_t ena_wdata;
  logic     evt_clr;
  logic     ena_we;

  irq_edge_detect #(
    .NUM_REFS(NUM_REFS), .SEL_W(SEL_W), .MODE_W(MODE_W)
  ) det_i (
    .clk(clk), .rst_n(rst_int_n), .lock_ok(lock_ok), .act_ref_sel(act_ref_sel),
    .pll_mode(pll_mode), .ref_active(ref_active), .ref_usable(ref_usable),
    .evt_pulse(evt_pulse)
  );

  irq_event_latch lat_i (
    .clk(clk), .rst_n(rst_int_n), .evt_pulse(evt_pulse), .evt_clr(evt_clr),
    .ena_we(ena_we), .ena_wdata(ena_wdata), .evt_q(evt_q), .ena_q(ena_q),
    .irq_n(irq_n)
  );

  irq_reg_decode #(
    .ADDR_W(ADDR_W), .EVT_ADDR(EVT_ADDR), .ENA_ADDR(ENA_ADDR)
  ) dec_i (
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .evt_q(evt_q), .ena_q(ena_q), .evt_clr(evt_clr), .ena_we(ena_we),
    .ena_wdata(ena_wdata), .bus_rdata(bus_rdata)
  );
endmodule

// File: rtl/irq_event_ctrl_chk.sv
module irq_event_ctrl_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] EVT_ADDR = 8'h12,
  parameter logic [ADDR_W-1:0] ENA_ADDR = 8'h13
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              lock_ok,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        evt_pulse,
  input logic [7:0]        evt_q,
  input logic [7:0]        ena_q,
  input logic              irq_n
);
  a_r2_enable_store: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_wr && bus_addr == ENA_ADDR) |=> (ena_q == $past(bus_wdata)));

  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(bus_rd && bus_addr == EVT_ADDR) |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  a_r4_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_int_n)
    !irq_n |-> (ena_q != 8'h00 && evt_q != 8'h00));

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_rd && bus_addr == EVT_ADDR && evt_pulse == 8'h00) |=> (evt_q == 8'h00));

  a_r6_event_kept: assert property (@(posedge clk) disable iff (!rst_int_n)
    (evt_pulse != 8'h00) |=> ((evt_q & $past(evt_pulse)) == $past(evt_pulse)));

  a_r7_write_ignored: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_wr && bus_addr == EVT_ADDR && !bus_rd && evt_pulse == 8'h00) |=> $stable(evt_q));

  a_r8_rise_no_loss: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(lock_ok) |-> !evt_pulse[7]);
endmodule

bind irq_event_ctrl irq_event_ctrl_chk #(
  .ADDR_W(ADDR_W), .EVT_ADDR(EVT_ADDR), .ENA_ADDR(ENA_ADDR)
) chk_i (
  .clk(clk), .rst_int_n(rst_int_n), .lock_ok(lock_ok), .bus_addr(bus_addr),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .evt_pulse(evt_pulse),
  .evt_q(evt_q), .ena_q(ena_q), .irq_n(irq_n)
);

// File: tb/irq_event_ctrl_tb.sv
module irq_event_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       lock_ok;
  logic [2:0] act_ref_sel;
  logic [1:0] pll_mode;
  logic [7:0] ref_active;
  logic [7:0] ref_usable;
  logic [7:0] bus_addr;
  logic       bus_rd;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       irq_n;

  always #5 clk = ~clk;

  irq_event_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .lock_ok(lock_ok), .act_ref_sel(act_ref_sel),
    .pll_mode(pll_mode), .ref_active(ref_active), .ref_usable(ref_usable),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench model state
  logic [7:0] m_evt, m_ena, m_pact, m_puse;
  logic [2:0] m_psel;
  logic [1:0] m_pmode;
  logic       m_plock, m_primed, m_rst;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_det();
    logic [7:0] d;
    d    = '0;
    d[7] = m_plock & ~lock_ok;
    d[6] = act_ref_sel != m_psel;
    d[5] = pll_mode != m_pmode;
    d[4] = |(ref_active & ~m_pact);
    d[3] = |(~ref_active & m_pact);
    d[2] = |(ref_usable & ~m_puse);
    d[1] = |(~ref_usable & m_puse);
    d[0] = (ref_active != m_pact) || (ref_usable != m_puse);
    return m_primed ? d : 8'h00;
  endfunction

  // Inputs must already be set (after a negedge). Checks outputs, then runs one edge.
  task automatic step(input string tag);
    logic [7:0] exp_rd, det;
    #1;
    if (bus_addr == 8'h12)      exp_rd = m_evt;
    else if (bus_addr == 8'h13) exp_rd = m_ena;
    else                        exp_rd = 8'h00;
    check({tag, bus_addr == 8'h12 ? " R3/R5 evt read" :
           bus_addr == 8'h13 ? " R2 ena read" : " R7 unmapped read"}, bus_rdata, exp_rd);
    check({tag, " R4 irq_n"}, {7'd0, irq_n}, {7'd0, ~|(m_evt & m_ena)});
    det = model_det();
    @(posedge clk);
    if (!m_rst) begin
      m_evt = ((bus_rd && bus_addr == 8'h12) ? 8'h00 : m_evt) | det;
      if (bus_wr && bus_addr == 8'h13) m_ena = bus_wdata;
      m_plock = lock_ok; m_psel = act_ref_sel; m_pmode = pll_mode;
      m_pact = ref_active; m_puse = ref_usable; m_primed = 1'b1;
    end
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    bus_addr = a; bus_rd = 1'b1; step(tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; step(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  logic [15:0] lfsr;

  initial begin
    m_evt = '0; m_ena = '0; m_pact = '0; m_puse = '0; m_psel = '0; m_pmode = '0;
    m_plock = 1'b0; m_primed = 1'b0; m_rst = 1'b1;
    rst_n = 1'b0;
    // R12: nonzero status already present while in reset
    lock_ok = 1'b1; act_ref_sel = 3'd5; pll_mode = 2'd2;
    ref_active = 8'hA5; ref_usable = 8'h3C;
    bus_addr = 8'h12; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
    repeat (2) @(negedge clk);
    // R1: values during reset
    bus_addr = 8'h12; step("R1 in reset");
    bus_addr = 8'h13; step("R1 in reset");
    rst_n = 1'b1;
    bus_addr = 8'h13; step("R1 sync");
    bus_addr = 8'h12; step("R1 sync");
    m_rst = 1'b0;
    bus_addr = 8'h12; step("R12 prime");
    bus_addr = 8'h12; step("R12 after prime");
    bus_addr = 8'h13; step("R1 after reset");

    // R2: exhaustive enable write/read-back
    for (int v = 0; v < 256; v++) begin
      wr(8'h13, v[7:0], "R2 write");
      bus_addr = 8'h13; step("R2 readback");
    end
    wr(8'h13, 8'hFF, "R4 enable all");

    // R8: lock rise gives nothing, fall gives bit 7
    lock_ok = 1'b0; bus_addr = 8'h12; step("R8 fall");
    check("R8 lock lost bit", bus_rdata, 8'h80);
    rd(8'h12, "R5 clear");
    lock_ok = 1'b1; bus_addr = 8'h12; step("R8 rise");
    check("R8 rise no event", bus_rdata, 8'h00);

    // R9/R10: each reference, both directions
    for (int i = 0; i < 8; i++) begin
      ref_active[i] = ~ref_active[i]; bus_addr = 8'h12; step("R9 act");
      rd(8'h12, "R9 act read");
      ref_active[i] = ~ref_active[i]; bus_addr = 8'h12; step("R9 act back");
      rd(8'h12, "R9 act back read");
      ref_usable[i] = ~ref_usable[i]; bus_addr = 8'h12; step("R10 use");
      rd(8'h12, "R10 use read");
      ref_usable[i] = ~ref_usable[i]; bus_addr = 8'h12; step("R10 use back");
      rd(8'h12, "R10 use back read");
    end
    // R11
    act_ref_sel = 3'd1; bus_addr = 8'h12; step("R11 sel");
    check("R11 sel bit", bus_rdata, 8'h40);
    rd(8'h12, "R11 clear");
    pll_mode = 2'd0; bus_addr = 8'h12; step("R11 mode");
    check("R11 mode bit", bus_rdata, 8'h20);

    // R6: event lands in the cycle of the clearing read
    act_ref_sel = 3'd4; rd(8'h12, "R6 coincide");
    bus_addr = 8'h12; step("R6 kept");
    check("R6 survived bit", bus_rdata, 8'h40);

    // R7: writes to event address ignored, unmapped reads return 0
    wr(8'h12, 8'hFF, "R7 write evt");
    wr(8'h12, 8'h00, "R7 write evt");
    rd(8'h11, "R7"); rd(8'h14, "R7"); rd(8'h00, "R7"); rd(8'hFF, "R7");

    // R3/R4: each single event under every single-bit and empty enable
    for (int e = 0; e < 9; e++) begin
      wr(8'h13, (e == 8) ? 8'h00 : (8'h01 << e), "R4 ena");
      rd(8'h12, "R5 clear");
      lock_ok = 1'b0; bus_addr = 8'h12; step("R3 latch disabled ok");
      lock_ok = 1'b1; act_ref_sel = act_ref_sel + 3'd1; bus_addr = 8'h12; step("R3");
      pll_mode = pll_mode + 2'd1; ref_active[0] = ~ref_active[0]; bus_addr = 8'h12; step("R3");
      ref_usable[1] = ~ref_usable[1]; bus_addr = 8'h12; step("R3");
      rd(8'h12, "R5 read");
    end

    // mixed pseudo-random phase
    lfsr = 16'hACE1;
    for (int c = 0; c < 4000; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[4:0] == 5'd3) lock_ok = ~lock_ok;
      if (lfsr[3:0] == 4'd0) ref_active[lfsr[6:4]] = ~ref_active[lfsr[6:4]];
      if (lfsr[7:4] == 4'd9) ref_usable[lfsr[10:8]] = ~ref_usable[lfsr[10:8]];
      if (lfsr[11:7] == 5'd5) act_ref_sel = lfsr[2:0];
      if (lfsr[12:8] == 5'd7) pll_mode = lfsr[1:0];
      case (lfsr[15:14])
        2'd0: bus_addr = lfsr[13:6];
        2'd1: bus_addr = 8'h13;
        default: bus_addr = 8'h12;
      endcase
      bus_rd = lfsr[12] & lfsr[9];
      bus_wr = lfsr[11] & lfsr[5] & ~bus_rd;
      bus_wdata = lfsr[7:0] ^ lfsr[15:8];
      step("R3-mix R5/R6/R7 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule